// File: doc/BRIEF.md
# Central Bus Arbiter with Hidden Arbitration and Parking

This block decides which of several masters on a shared bus may start the next transfer. Each master has its own active-low request input and its own active-low grant output. The arbiter watches the two bus-activity strobes, frame and initiator-ready, both active low. From them it learns when the granted master has started a transfer and when the bus is idle.

A master that holds the grant starts a transfer by pulling frame low while the bus is idle. The arbiter detects this as a falling edge of frame while a grant is held. From then on, that master has used its win. If another master is waiting, the grant moves on while the transfer is still running, so arbitration overlaps the transfer. Requesters are served in round-robin order. When nobody requests, the grant can be parked on a master, chosen by a runtime mode: a fixed index, the last master that used the bus, or no parking at all.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is asserted, every grant output is high. After reset, the rotation pointer behaves as if master N-1 was the last user, so master 0 has first priority.
- R2: At most one grant output is low in any cycle.
- R3: The grant never moves directly from one master to another. Between two different grant holders there is at least one cycle with all grants high.
- R4: In a cycle with no grant held and at least one request low, the selected requester's grant goes low at the next clock edge. This happens whether the bus is busy or idle.
- R5: The selected requester is the first requesting index above the pointer, wrapping from N-1 to 0. The pointer is the index of the master that most recently started a transfer. A start is frame sampled high in one cycle and low in the next while a grant is held, and it counts in the same cycle it is seen.
- R6: A grant holder that is still requesting and has not started a transfer since it was granted keeps its grant, even if another master would win.
- R7: Once the holder has started a transfer (or has dropped its request), a different winner causes the grant to be removed at the next edge, even while frame is still low. The winner is then granted one cycle later.
- R8: With park_mode 2'b00 or 2'b11 and no request low, any held grant is removed and no grant is issued.
- R9: With park_mode 2'b01 and no request low, the grant is parked on master park_id.
- R10: With park_mode 2'b10 and no request low, the grant is parked on the master that most recently started a transfer.
- R11: A parking grant is issued from the no-grant state only in a cycle where frame and initiator-ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | N_MASTERS | Per-master request, active low, bit i for master i |
| frame_n | input | 1 | Bus frame strobe, active low |
| irdy_n | input | 1 | Initiator-ready strobe, active low |
| park_mode | input | 2 | Parking policy: 00 none, 01 fixed, 10 last user, 11 none |
| park_id | input | IDW | Master index used by fixed parking |
| gnt_n | output | N_MASTERS | Per-master grant, active low, bit i for master i |

## Verification
The bench targets the moment a start is seen while another master is waiting. A design that keeps the old rotation pointer in that cycle would hand the grant back to the same master. A design that skips the idle gap would show two grants changing in one edge. It also tests a holder that was granted but has not yet started while a competitor requests; a design that pre-empts too early starves masters that are slow to begin. Parking is checked across all three policies and while the bus is busy. A parking grant issued while frame is low, or left asserted in no-park mode, is reported directly. A full rotation through all four masters with every request held confirms that the order wraps from 3 back to 0.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int N_MASTERS = 4,
  parameter int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_n,
  input  logic                 frame_n,
  input  logic                 irdy_n,
  input  logic [1:0]           park_mode,
  input  logic [IDW-1:0]       park_id,
  output logic [N_MASTERS-1:0] gnt_n
);

  localparam logic [IDW-1:0] RESET_PTR = IDW'(N_MASTERS - 1);

  logic [N_MASTERS-1:0] gnt_q, gnt_d, req;
  logic [IDW-1:0]       last_id, cur_id, ptr, win_id, tgt_id, park_tgt;
  logic                 started, frame_q, start_now, have_gnt, win_found;
  logic                 park_on, park_id_ok, tgt_valid, any_req, holder_req, may_switch, bus_idle;

  assign req        = ~req_n;
  assign gnt_n      = ~gnt_q;
  assign any_req    = |req;
  assign have_gnt   = |gnt_q;
  assign bus_idle   = frame_n & irdy_n;
  assign start_now  = have_gnt & frame_q & ~frame_n;
  assign ptr        = start_now ? cur_id : last_id;
  assign holder_req = |(gnt_q & req);
  assign may_switch = ~holder_req | started | start_now;

  generate
    if ((1 << IDW) == N_MASTERS) begin : g_full_ids
      assign park_id_ok = 1'b1;
    end else begin : g_part_ids
      assign park_id_ok = int'(park_id) < N_MASTERS;
    end
  endgenerate

  assign park_on   = (park_mode == 2'b10) || ((park_mode == 2'b01) && park_id_ok);
  assign park_tgt  = (park_mode == 2'b10) ? last_id : park_id;
  assign tgt_valid = any_req | park_on;
  assign tgt_id    = any_req ? win_id : park_tgt;

  always_comb begin
    cur_id = '0;
    for (int i = 0; i < N_MASTERS; i++)
      if (gnt_q[i]) cur_id = IDW'(i);
  end

  always_comb begin
    int idx;
    win_found = 1'b0;
    win_id    = '0;
    for (int k = 1; k <= N_MASTERS; k++) begin
      idx = (int'(ptr) + k) % N_MASTERS;
      if (!win_found && req[idx]) begin
        win_found = 1'b1;
        win_id    = IDW'(idx);
      end
    end
  end

  always_comb begin
    gnt_d = gnt_q;
    if (!have_gnt) begin
      if (tgt_valid && (any_req || bus_idle)) begin
        gnt_d         = '0;
        gnt_d[tgt_id] = 1'b1;
      end
    end else if (!tgt_valid || tgt_id != cur_id) begin
      if (may_switch) gnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q   <= '0;
      last_id <= RESET_PTR;
      started <= 1'b0;
      frame_q <= 1'b1;
    end else begin
      gnt_q   <= gnt_d;
      frame_q <= frame_n;
      if (start_now) last_id <= cur_id;
      started <= (gnt_d == gnt_q) ? (started | start_now) : 1'b0;
    end
  end

endmodule

module bus_arbiter_props #(
  parameter int N_MASTERS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req_n,
  input logic                 frame_n,
  input logic                 irdy_n,
  input logic [1:0]           park_mode,
  input logic [N_MASTERS-1:0] gnt_n,
  input logic                 started,
  input logic                 frame_q
);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~gnt_n) <= 1); // R2

  AST_SWITCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n != '1) |=> (gnt_n == '1 || gnt_n == $past(gnt_n))); // R3

  AST_HOLD_UNSTARTED: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n != '1 && (~gnt_n & ~req_n) != '0 && !started && !(frame_q && !frame_n))
    |=> gnt_n == $past(gnt_n)); // R6

  AST_NO_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (park_mode[0] == park_mode[1] && req_n == '1 && gnt_n == '1) |=> gnt_n == '1); // R8

  AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n == '1 && req_n == '1) |=> (gnt_n == '1 || $past(frame_n && irdy_n))); // R11

endmodule

bind bus_arbiter bus_arbiter_props #(.N_MASTERS(N_MASTERS)) u_props (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .park_mode(park_mode), .gnt_n(gnt_n), .started(started), .frame_q(frame_q)
);

// File: tb/tb_bus_arbiter.sv
module tb_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_n = 4'hF;
  logic       frame_n = 1'b1;
  logic       irdy_n = 1'b1;
  logic [1:0] park_mode = 2'b00;
  logic [1:0] park_id = 2'd0;
  logic [3:0] gnt_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t q[$];

  bus_arbiter #(.N_MASTERS(4)) dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .park_mode(park_mode), .park_id(park_id), .gnt_n(gnt_n)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s grant got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] md, input logic [1:0] pid, input logic [3:0] rq,
                      input logic fr, input logic ir, input logic [3:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    park_mode = md; park_id = pid; req_n = ~rq; frame_n = fr; irdy_n = ir;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(~gnt_n === it.exp, it.tag, ~gnt_n, it.exp);
      end
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    check(gnt_n === 4'hF, "R1 reset", ~gnt_n, 4'h0);
    rst_n = 1'b1;
    step(0, 0, 4'b0000, 1, 1, 4'b0000, "R8 idle no park");
    step(0, 0, 4'b0001, 1, 1, 4'b0001, "R1 R4 first grant to 0");
    step(0, 0, 4'b0001, 0, 1, 4'b0001, "R6 holder starts");
    step(0, 0, 4'b0100, 0, 0, 4'b0000, "R3 gap before switch");
    step(0, 0, 4'b0100, 0, 1, 4'b0100, "R7 grant during busy bus");
    step(0, 0, 4'b0100, 1, 0, 4'b0100, "R6 hold");
    step(0, 0, 4'b0100, 1, 1, 4'b0100, "R6 hold idle");
    step(0, 0, 4'b0110, 0, 1, 4'b0000, "R7 start frees grant");
    step(0, 0, 4'b0110, 0, 1, 4'b0010, "R5 rotate to 1");
    step(0, 0, 4'b0110, 0, 1, 4'b0010, "R6 unstarted holder kept");
    step(0, 0, 4'b0110, 1, 1, 4'b0010, "R6 unstarted holder idle");
    step(0, 0, 4'b0110, 0, 1, 4'b0000, "R7 start seen same cycle");
    step(0, 0, 4'b0110, 0, 1, 4'b0100, "R5 rotate to 2");
    step(0, 0, 4'b0000, 1, 1, 4'b0000, "R8 release");
    step(0, 0, 4'b0000, 1, 1, 4'b0000, "R8 stays empty");
    step(2, 0, 4'b0000, 1, 1, 4'b0010, "R10 park on last user 1");
    step(2, 0, 4'b0000, 1, 1, 4'b0010, "R10 park held");
    step(2, 0, 4'b0001, 1, 1, 4'b0000, "R3 unpark gap");
    step(2, 0, 4'b0001, 1, 1, 4'b0001, "R4 grant 0");
    step(2, 0, 4'b0001, 0, 1, 4'b0001, "R6 start 0");
    step(2, 0, 4'b0000, 1, 1, 4'b0001, "R10 park stays on 0");
    step(1, 3, 4'b0000, 1, 1, 4'b0000, "R3 gap to fixed park");
    step(1, 3, 4'b0000, 1, 1, 4'b1000, "R9 fixed park on 3");
    step(1, 3, 4'b1000, 1, 1, 4'b1000, "R5 parked requester kept");
    step(1, 3, 4'b1000, 0, 1, 4'b1000, "R5 parked requester starts");
    step(1, 1, 4'b0000, 0, 1, 4'b0000, "R9 move fixed park");
    step(1, 1, 4'b0000, 0, 1, 4'b0000, "R11 no park while busy");
    step(1, 1, 4'b0000, 1, 1, 4'b0010, "R9 R11 park when idle");
    step(0, 0, 4'b1111, 1, 1, 4'b0010, "R6 no preempt before start");
    step(0, 0, 4'b1111, 0, 1, 4'b0000, "R7 switch after start");
    step(0, 0, 4'b1111, 0, 1, 4'b0100, "R5 all req to 2");
    step(0, 0, 4'b1111, 1, 1, 4'b0100, "R6 hold 2");
    step(0, 0, 4'b1111, 0, 1, 4'b0000, "R3 gap");
    step(0, 0, 4'b1111, 0, 1, 4'b1000, "R5 all req to 3");
    step(0, 0, 4'b1111, 1, 1, 4'b1000, "R6 hold 3");
    step(0, 0, 4'b1111, 0, 1, 4'b0000, "R2 gap");
    step(0, 0, 4'b1111, 0, 1, 4'b0001, "R5 wrap to 0");
    step(3, 0, 4'b0000, 1, 1, 4'b0000, "R8 mode 11 no park");
    step(3, 0, 4'b0000, 1, 1, 4'b0000, "R8 mode 11 stays empty");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule